// File: doc/BRIEF.md
# Card Command Response Handler

This block sits between a host controller's register file and a card-side command engine. Software writes a 32-bit argument as two 16-bit halves and then a 16-bit command word. The handler decodes that word and sends the command index and argument to the card interface as a one-cycle request. It then waits for the card interface to return a byte stream and its length. The response is checked against the response type chosen in the command word. The check covers the minimum length, the error bits of the card status and the ready bit of the operating-conditions reply. The outcome is recorded as sticky status bits, and the response bytes are packed into eight 16-bit readable registers.

Status bits are cleared by writing ones to them. An interrupt output is raised while any enabled status bit is set. A command whose command type is address-with-data emits a one-cycle transfer-start pulse together with the data direction. The data path uses that pulse to reset its buffer pointers.

Top module: `card_cmd_rsp`

## Requirements
- R1: Command word fields: bits 5:0 index, bit 7 init flag, bits 10:8 response type, bit 11 busy, bits 13:12 command type, bit 15 direction. An accepted write appears on `last_cmd` and its index appears on `card_index` one cycle later.
- R2: A command write is ignored while `enable` is low or while a response is still awaited. An accepted write clears all response registers.
- R3: A command with the init flag set and index 0 sets only status bit 0 and raises no request. Any other accepted command raises `card_req` for exactly one cycle.
- R4: `arg_lo_wr` loads argument bits 15:0 and `arg_hi_wr` loads bits 31:16 from `arg_half`. `card_arg` shows the assembled value.
- R5: Response types 1, 3 and 6 need at least 4 bytes, and type 2 needs 16 bytes. A shorter response sets status bit 7 (timeout) instead of bit 0 and leaves the response registers at zero.
- R6: For type 1, with or without the busy bit, the 32-bit card status is formed from bytes 0..3 with byte 0 most significant. If it has any bit of mask 0xFDF90000 set, status bit 14 is set.
- R7: For type 6, if the 16-bit value {byte 2, byte 3} has any bit of mask 0xE008 set, status bit 14 is set.
- R8: For type 3, if bit 31 of the 32-bit reply is clear, status bit 12 is set.
- R9: On a response that passes its length check, register 7−k receives {byte 2k, byte 2k+1}, for k = 0..7. `rsp_regs` holds register j at bits 16j+15:16j.
- R10: A response that is not timed out sets status bit 0. Index 12 sets bits 0 and 2. Types 0, 4, 5 and 7 skip all checks and leave the registers cleared.
- R11: Writing ones through `stat_clr` clears those status bits, but a bit being set in the same cycle wins. IE keeps bits 14:0, and `irq` is high when status bits 14:0 AND IE are non-zero.
- R12: An accepted non-init0 command with command type 3 pulses `xfer_start` together with `card_req`. `xfer_dir` takes bit 15 of that command.
- R13: `card_rsp_valid` while no response is awaited has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; command writes need it high |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Command word |
| arg_lo_wr | input | 1 | Write low argument half |
| arg_hi_wr | input | 1 | Write high argument half |
| arg_half | input | 16 | Argument half data |
| stat_clr_wr | input | 1 | Status clear strobe |
| stat_clr | input | 16 | Ones clear status bits |
| ie_wr | input | 1 | Interrupt-enable write strobe |
| ie_data | input | 16 | Interrupt-enable data (bit 15 dropped) |
| card_req | output | 1 | One-cycle command request |
| card_index | output | 6 | Command index to the card |
| card_arg | output | 32 | Command argument to the card |
| card_rsp_valid | input | 1 | Response available |
| card_rsp_len | input | 5 | Response length in bytes |
| card_rsp_bytes | input | 128 | Response bytes, byte i at bits 8i+7:8i |
| last_cmd | output | 16 | Last accepted command word |
| status | output | 16 | Sticky status bits |
| ie | output | 15 | Interrupt-enable bits |
| irq | output | 1 | Interrupt request |
| rsp_regs | output | 128 | Eight packed response registers |
| xfer_start | output | 1 | Data transfer start pulse |
| xfer_dir | output | 1 | Data transfer direction |

## Verification
Every result is registered. `last_cmd`, `card_req`, `card_index`, `xfer_start` and the init-0 status bit are due one clock after the edge that samples the command write. Status bits and response registers are due one clock after the edge that samples `card_rsp_valid`. A clear or IE write takes effect one clock after its strobe. The bench drives inputs on falling edges and updates its reference model on the rising edge, from the same sampled inputs. It then compares all outputs on the next falling edge, so every comparison lands exactly one register stage after its cause.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;
  localparam int IDX_W  = 6;
  localparam int CMD_W  = 16;
  localparam int STAT_W = 16;

  localparam int ST_DONE     = 0;
  localparam int ST_STOP     = 2;
  localparam int ST_TMO      = 7;
  localparam int ST_OCR_BUSY = 12;
  localparam int ST_RSP_ERR  = 14;

  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(12);
  localparam logic [1:0] CT_ADDR_DATA = 2'd3;

  typedef enum logic [2:0] {
    RT_NONE   = 3'd0,
    RT_SHORT  = 3'd1,
    RT_LONG   = 3'd2,
    RT_OCR    = 3'd3,
    RT_SHORTB = 3'd4,
    RT_ADDR   = 3'd6
  } rsp_kind_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             init;
    rsp_kind_e        kind;
    logic [1:0]       ctype;
    logic             dir;
  } cmd_fields_t;
endpackage

// File: rtl/cmdrsp_decode.sv
module cmdrsp_decode
  import cmdrsp_pkg::*;
(
  input  logic [CMD_W-1:0] word_i,
  output cmd_fields_t      fld_o,
  output logic             init0_o,
  output logic             adtc_o
);
  logic dec_unused;
  assign dec_unused = word_i[6] ^ word_i[14];

  always_comb begin
    fld_o.idx   = word_i[IDX_W-1:0];
    fld_o.init  = word_i[7];
    fld_o.ctype = word_i[13:12];
    fld_o.dir   = word_i[15];
    case (word_i[10:8])
      3'd1:    fld_o.kind = word_i[11] ? RT_SHORTB : RT_SHORT;
      3'd2:    fld_o.kind = RT_LONG;
      3'd3:    fld_o.kind = RT_OCR;
      3'd6:    fld_o.kind = RT_ADDR;
      default: fld_o.kind = RT_NONE;
    endcase
  end

  assign init0_o = fld_o.init && (fld_o.idx == '0);
  assign adtc_o  = (fld_o.ctype == CT_ADDR_DATA);
endmodule

// File: rtl/cmdrsp_eval.sv
module cmdrsp_eval
  import cmdrsp_pkg::*;
#(
  parameter int          RSP_BYTES   = 16,
  parameter int          LEN_W       = 5,
  parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
  parameter logic [15:0] R6_ERR_MASK = 16'hE008
) (
  input  rsp_kind_e         kind_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [31:0]       head_i,
  output logic [STAT_W-1:0] set_o,
  output logic              load_o,
  output logic              timeout_o
);
  localparam int SHORT_BYTES = 4;

  logic [31:0] word32;
  logic [15:0] word16;
  logic        need_short, need_long, err;

  assign word32 = {head_i[7:0], head_i[15:8], head_i[23:16], head_i[31:24]};
  assign word16 = word32[15:0];

  always_comb begin
    need_short = (kind_i inside {RT_SHORT, RT_SHORTB, RT_OCR, RT_ADDR});
    need_long  = (kind_i == RT_LONG);
    timeout_o  = (need_short && (len_i < LEN_W'(SHORT_BYTES))) ||
                 (need_long  && (len_i < LEN_W'(RSP_BYTES)));
    load_o     = (need_short || need_long) && !timeout_o;

    err = 1'b0;
    if (!timeout_o) begin
      case (kind_i)
        RT_SHORT, RT_SHORTB: err = |(word32 & R1_ERR_MASK);
        RT_ADDR:             err = |(word16 & R6_ERR_MASK);
        default:             err = 1'b0;
      endcase
    end

    set_o = '0;
    if (timeout_o) begin
      set_o[ST_TMO] = 1'b1;
    end else begin
      set_o[ST_DONE] = 1'b1;
      set_o[ST_STOP] = (idx_i == STOP_IDX);
    end
    set_o[ST_RSP_ERR]  = err;
    set_o[ST_OCR_BUSY] = (kind_i == RT_OCR) && !timeout_o && !word32[31];
  end
endmodule

// File: rtl/cmdrsp_status.sv
module cmdrsp_status
  import cmdrsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid_i,
  input  logic [STAT_W-1:0] set_bits_i,
  input  logic              clr_wr_i,
  input  logic [STAT_W-1:0] clr_bits_i,
  input  logic              ie_wr_i,
  input  logic [STAT_W-1:0] ie_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-2:0] ie_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] status_q, status_d;
  logic [STAT_W-2:0] ie_q, ie_d;
  logic              ie_unused;

  assign ie_unused = ie_data_i[STAT_W-1];

  always_comb begin
    status_d = status_q;
    if (clr_wr_i)    status_d = status_d & ~clr_bits_i;
    if (set_valid_i) status_d = status_d | set_bits_i;
    ie_d = ie_wr_i ? ie_data_i[STAT_W-2:0] : ie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ie_q     <= '0;
    end else begin
      status_q <= status_d;
      ie_q     <= ie_d;
    end
  end

  assign status_o = status_q;
  assign ie_o     = ie_q;
  assign irq_o    = |(status_q[STAT_W-2:0] & ie_q);

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && !set_valid_i) |=> ((status_q & $past(clr_bits_i)) == '0)); // R11
endmodule

// File: rtl/card_cmd_rsp.sv
module card_cmd_rsp
  import cmdrsp_pkg::*;
#(
  parameter int          RSP_WORDS   = 8,
  parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
  parameter logic [15:0] R6_ERR_MASK = 16'hE008,
  localparam int         RSP_BYTES   = 2 * RSP_WORDS,
  localparam int         LEN_W       = $clog2(RSP_BYTES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     cmd_wr,
  input  logic [CMD_W-1:0]         cmd_word,
  input  logic                     arg_lo_wr,
  input  logic                     arg_hi_wr,
  input  logic [15:0]              arg_half,
  input  logic                     stat_clr_wr,
  input  logic [STAT_W-1:0]        stat_clr,
  input  logic                     ie_wr,
  input  logic [STAT_W-1:0]        ie_data,
  output logic                     card_req,
  output logic [IDX_W-1:0]         card_index,
  output logic [31:0]              card_arg,
  input  logic                     card_rsp_valid,
  input  logic [LEN_W-1:0]         card_rsp_len,
  input  logic [8*RSP_BYTES-1:0]   card_rsp_bytes,
  output logic [CMD_W-1:0]         last_cmd,
  output logic [STAT_W-1:0]        status,
  output logic [STAT_W-2:0]        ie,
  output logic                     irq,
  output logic [16*RSP_WORDS-1:0]  rsp_regs,
  output logic                     xfer_start,
  output logic                     xfer_dir
);
  typedef enum logic {ST_IDLE, ST_WAIT} ph_e;

  localparam logic [STAT_W-1:0] DONE_ONLY = STAT_W'(1) << ST_DONE;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  ph_e              ph_q, ph_d;
  logic [CMD_W-1:0] last_q, last_d;
  logic [31:0]      arg_q, arg_d;
  logic             req_q, req_d, xs_q, xs_d, dir_q, dir_d;
  logic             accept, done;

  cmd_fields_t      new_fld_unused, cur_fld;
  logic             new_init0, new_adtc, cur_init0_unused, cur_adtc_unused;

  cmdrsp_decode u_dec_new (
    .word_i(cmd_word), .fld_o(new_fld_unused), .init0_o(new_init0), .adtc_o(new_adtc));
  cmdrsp_decode u_dec_cur (
    .word_i(last_q), .fld_o(cur_fld), .init0_o(cur_init0_unused), .adtc_o(cur_adtc_unused));

  logic [STAT_W-1:0] eval_set, set_bits;
  logic              eval_load, eval_tmo, set_valid;

  cmdrsp_eval #(
    .RSP_BYTES(RSP_BYTES), .LEN_W(LEN_W),
    .R1_ERR_MASK(R1_ERR_MASK), .R6_ERR_MASK(R6_ERR_MASK)
  ) u_eval (
    .kind_i(cur_fld.kind), .idx_i(cur_fld.idx), .len_i(card_rsp_len),
    .head_i(card_rsp_bytes[31:0]), .set_o(eval_set), .load_o(eval_load),
    .timeout_o(eval_tmo));

  assign accept    = cmd_wr && enable && (ph_q == ST_IDLE);
  assign done      = (ph_q == ST_WAIT) && card_rsp_valid;
  assign set_valid = (accept && new_init0) || done;
  assign set_bits  = done ? eval_set : DONE_ONLY;

  cmdrsp_status u_stat (
    .clk(clk), .rst_n(rst_sn), .set_valid_i(set_valid), .set_bits_i(set_bits),
    .clr_wr_i(stat_clr_wr), .clr_bits_i(stat_clr), .ie_wr_i(ie_wr),
    .ie_data_i(ie_data), .status_o(status), .ie_o(ie), .irq_o(irq));

  always_comb begin
    ph_d   = ph_q;
    last_d = last_q;
    arg_d  = arg_q;
    req_d  = 1'b0;
    xs_d   = 1'b0;
    dir_d  = dir_q;
    if (arg_lo_wr) arg_d[15:0]  = arg_half;
    if (arg_hi_wr) arg_d[31:16] = arg_half;
    if (accept) begin
      last_d = cmd_word;
      if (!new_init0) begin
        req_d = 1'b1;
        ph_d  = ST_WAIT;
        if (new_adtc) begin
          xs_d  = 1'b1;
          dir_d = cmd_word[15];
        end
      end
    end else if (done) begin
      ph_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ph_q   <= ST_IDLE;
      last_q <= '0;
      arg_q  <= '0;
      req_q  <= 1'b0;
      xs_q   <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      last_q <= last_d;
      arg_q  <= arg_d;
      req_q  <= req_d;
      xs_q   <= xs_d;
      dir_q  <= dir_d;
    end
  end

  // response registers: word j takes byte pair RSP_WORDS-1-j
  for (genvar j = 0; j < RSP_WORDS; j++) begin : g_rsp
    localparam int K = RSP_WORDS - 1 - j;
    logic [15:0] wq, wd;
    always_comb begin
      wd = wq;
      if (accept)                 wd = '0;
      else if (done && eval_load) wd = {card_rsp_bytes[16*K +: 8], card_rsp_bytes[16*K+8 +: 8]};
    end
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) wq <= '0;
      else         wq <= wd;
    end
    assign rsp_regs[16*j +: 16] = wq;
  end

  assign card_req   = req_q;
  assign card_index = last_q[IDX_W-1:0];
  assign card_arg   = arg_q;
  assign last_cmd   = last_q;
  assign xfer_start = xs_q;
  assign xfer_dir   = dir_q;

  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_wr && !enable) |=> $stable(last_cmd)); // R2
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_wr && ph_q == ST_WAIT) |=> !card_req); // R2
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_sn)
    accept |=> (rsp_regs == '0)); // R2
  AST_INIT0_SILENT: assert property (@(posedge clk) disable iff (!rst_sn)
    (accept && new_init0) |=> (!card_req && status[ST_DONE])); // R3
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_sn)
    card_req |=> !card_req); // R3
  AST_TIMEOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && eval_tmo) |=> status[ST_TMO]); // R5
  AST_XFER_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_sn)
    xfer_start |-> card_req); // R12
endmodule

// File: tb/card_cmd_rsp_tb.sv
module card_cmd_rsp_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0, cmd_wr = 1'b0, arg_lo_wr = 1'b0, arg_hi_wr = 1'b0;
  logic [15:0]  cmd_word = '0, arg_half = '0, stat_clr = '0, ie_data = '0;
  logic         stat_clr_wr = 1'b0, ie_wr = 1'b0, card_rsp_valid = 1'b0;
  logic [4:0]   card_rsp_len = '0;
  logic [127:0] card_rsp_bytes = '0;
  logic         card_req, irq, xfer_start, xfer_dir;
  logic [5:0]   card_index;
  logic [31:0]  card_arg;
  logic [15:0]  last_cmd, status;
  logic [14:0]  ie;
  logic [127:0] rsp_regs;

  card_cmd_rsp u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_last = '0, m_status = '0, m_rsp[8];
  logic [14:0] m_ie = '0;
  logic [31:0] m_arg = '0;
  logic        m_busy = 0, m_req = 0, m_xs = 0, m_dir = 0;
  logic [15:0] nst;
  logic [127:0] m_flat;

  task automatic model_eval();
    int t, need, idx;
    logic [31:0] w;
    logic [7:0] b[16];
    for (int i = 0; i < 16; i++) b[i] = card_rsp_bytes[8*i +: 8];
    t = m_last[10:8]; idx = m_last[5:0];
    need = (t == 2) ? 16 : (t == 1 || t == 3 || t == 6) ? 4 : 0;
    w = {b[0], b[1], b[2], b[3]};
    if (need != 0 && card_rsp_len < need) nst[7] = 1;
    else begin
      nst[0] = 1;
      if (idx == 12) nst[2] = 1;
      if (need != 0)
        for (int k = 0; k < 8; k++) m_rsp[7-k] = {b[2*k], b[2*k+1]};
      if (t == 1 && (w & 32'hFDF90000) != 0) nst[14] = 1;
      if (t == 6 && (w[15:0] & 16'hE008) != 0) nst[14] = 1;
      if (t == 3 && !w[31]) nst[12] = 1;
    end
  endtask

  initial for (int i = 0; i < 8; i++) m_rsp[i] = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      nst = m_status;
      m_req = 0; m_xs = 0;
      if (stat_clr_wr) nst = nst & ~stat_clr;
      if (ie_wr) m_ie = ie_data[14:0];
      if (arg_lo_wr) m_arg[15:0] = arg_half;
      if (arg_hi_wr) m_arg[31:16] = arg_half;
      if (cmd_wr && enable && !m_busy) begin
        m_last = cmd_word;
        for (int i = 0; i < 8; i++) m_rsp[i] = '0;
        if (cmd_word[7] && cmd_word[5:0] == 0) nst[0] = 1;
        else begin
          m_req = 1; m_busy = 1;
          if (cmd_word[13:12] == 2'd3) begin m_xs = 1; m_dir = cmd_word[15]; end
        end
      end else if (m_busy && card_rsp_valid) begin
        m_busy = 0;
        model_eval();
      end
      m_status = nst;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      for (int j = 0; j < 8; j++) m_flat[16*j +: 16] = m_rsp[j];
      chk("R1 last_cmd", last_cmd, m_last);
      chk("R3 card_req", card_req, m_req);
      chk("R1 card_index", card_index, m_last[5:0]);
      chk("R4 card_arg", card_arg, m_arg);
      chk("R11 status", status, m_status);
      chk("R11 ie", ie, m_ie);
      chk("R11 irq", irq, |(m_status[14:0] & m_ie));
      chk("R9 rsp_regs", rsp_regs, m_flat);
      chk("R12 xfer", {xfer_start, xfer_dir}, {m_xs, m_dir});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  logic got_req, got_xs;

  task automatic do_cmd(input logic [15:0] w, input int len, input logic [127:0] by, input bit clr_too);
    @(negedge clk); cmd_wr = 1; cmd_word = w;
    @(negedge clk); cmd_wr = 0; got_req = card_req; got_xs = xfer_start;
    if (card_req) begin
      card_rsp_valid = 1; card_rsp_len = 5'(len); card_rsp_bytes = by;
      if (clr_too) begin stat_clr_wr = 1; stat_clr = 16'hFFFF; end
      @(negedge clk); card_rsp_valid = 0; stat_clr_wr = 0;
    end
  endtask

  task automatic clr_all();
    @(negedge clk); stat_clr_wr = 1; stat_clr = 16'hFFFF;
    @(negedge clk); stat_clr_wr = 0;
  endtask

  function automatic logic [127:0] pat(input logic [7:0] b0, b1, b2, b3);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[8*i +: 8] = 8'hA0 + 8'(i);
    r[31:0] = {b3, b2, b1, b0};
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    cmp_on = 1;
    chk("R11 reset status", status, 16'h0);
    chk("R9 reset rsp", rsp_regs, '0);

    // R2: disabled write ignored
    do_cmd(16'h0102, 4, pat(0,0,0,0), 0);
    chk("R2 disabled last_cmd", last_cmd, 16'h0);
    chk("R2 disabled no req", got_req, 0);
    enable = 1;

    // R4: argument halves
    @(negedge clk); arg_lo_wr = 1; arg_half = 16'h5678;
    @(negedge clk); arg_lo_wr = 0; arg_hi_wr = 1; arg_half = 16'h1234;
    @(negedge clk); arg_hi_wr = 0;
    chk("R4 card_arg", card_arg, 32'h12345678);

    // R3: init with index 0
    do_cmd(16'h0080, 0, '0, 0);
    chk("R3 init0 no req", got_req, 0);
    @(negedge clk);
    chk("R3 init0 status", status, 16'h0001);
    clr_all();
    chk("R11 cleared", status, 16'h0);

    // R10/R9: type 1 good
    do_cmd(16'h0111, 4, pat(8'h00, 8'h00, 8'h09, 8'h00), 0);
    chk("R1 index", card_index, 6'd17);
    chk("R10 done", status, 16'h0001);
    chk("R9 reg7", rsp_regs[16*7 +: 16], 16'h0000);
    chk("R9 reg6", rsp_regs[16*6 +: 16], 16'h0900);
    chk("R9 reg0", rsp_regs[15:0], 16'hAEAF);
    clr_all();

    // R6: busy type 1 with error bit
    do_cmd(16'h0911, 4, pat(8'h80, 0, 0, 0), 0);
    chk("R6 err", status, 16'h4001);
    clr_all();

    // R5: type 2 short
    do_cmd(16'h0202, 15, pat(1, 2, 3, 4), 0);
    chk("R5 timeout", status, 16'h0080);
    chk("R5 rsp zero", rsp_regs, '0);
    clr_all();

    // R9: type 2 full
    do_cmd(16'h0202, 16, pat(8'hA0, 8'hA1, 8'hA2, 8'hA3), 0);
    chk("R9 long status", status, 16'h0001);
    chk("R9 long reg7", rsp_regs[16*7 +: 16], 16'hA0A1);
    clr_all();

    // R8: type 3
    do_cmd(16'h0329, 4, pat(8'h00, 8'hFF, 0, 0), 0);
    chk("R8 ocr busy", status, 16'h1001);
    clr_all();
    do_cmd(16'h0329, 4, pat(8'h80, 8'hFF, 0, 0), 0);
    chk("R8 ocr ready", status, 16'h0001);
    clr_all();

    // R7: type 6
    do_cmd(16'h0603, 4, pat(0, 0, 8'hE0, 0), 0);
    chk("R7 err", status, 16'h4001);
    clr_all();
    do_cmd(16'h0603, 4, pat(0, 0, 8'h01, 0), 0);
    chk("R7 ok", status, 16'h0001);
    clr_all();

    // R10: index 12 and no-response types
    do_cmd(16'h010C, 4, pat(0, 0, 0, 0), 0);
    chk("R10 stop", status, 16'h0005);
    clr_all();
    do_cmd(16'h0000, 0, pat(0, 0, 0, 0), 0);
    chk("R10 nore req", got_req, 1);
    chk("R10 nore status", status, 16'h0001);
    chk("R10 nore rsp", rsp_regs, '0);
    do_cmd(16'h0505, 0, pat(0, 0, 0, 0), 0);
    chk("R10 type5", status, 16'h0001);

    // R11: set wins over clear, IE width, irq
    do_cmd(16'h0111, 4, pat(0, 0, 0, 0), 1);
    chk("R11 set priority", status, 16'h0001);
    @(negedge clk); ie_wr = 1; ie_data = 16'hFFFF;
    @(negedge clk); ie_wr = 0;
    chk("R11 ie width", ie, 15'h7FFF);
    chk("R11 irq", irq, 1);
    clr_all();
    chk("R11 irq low", irq, 0);

    // R12: address-data command
    do_cmd(16'hB111, 4, pat(0, 0, 0, 0), 0);
    chk("R12 start", got_xs, 1);
    chk("R12 dir", xfer_dir, 1);
    clr_all();

    // R13: stray response
    @(negedge clk); card_rsp_valid = 1; card_rsp_len = 16; card_rsp_bytes = pat(8'h80, 1, 2, 3);
    @(negedge clk); card_rsp_valid = 0;
    chk("R13 status", status, 16'h0);
    chk("R13 rsp", rsp_regs[16*7 +: 16], 16'h0);

    // R2: write while waiting
    @(negedge clk); cmd_wr = 1; cmd_word = 16'h0111;
    @(negedge clk); cmd_word = 16'h0102;
    @(negedge clk); cmd_wr = 0;
    chk("R2 busy last_cmd", last_cmd, 16'h0111);
    chk("R2 busy no req", card_req, 0);
    card_rsp_valid = 1; card_rsp_len = 4; card_rsp_bytes = pat(0, 0, 0, 0);
    @(negedge clk); card_rsp_valid = 0;
    chk("R2 busy done", status, 16'h0001);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule